// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block decides which clocks of a small 8-bit microcontroller run and when the core is reset. It keeps a mode state with three values: full run, idle (the CPU clock is gated while the peripheral and interrupt clock keeps running), and power-down (the oscillator and every clock are stopped). Software moves the core into idle or power-down through request strobes. An enabled pending interrupt brings the core out of idle. Only a hardware reset brings it out of power-down.

The external reset pin is sampled on the oscillator clock. The internal reset is raised only after the pin has been held high for two whole machine cycles. A machine cycle is `MC_CLKS` oscillator clocks, and the reset width is `RST_MC` machine cycles. When a reset pulse arrives while the core is idle, the CPU clock starts again at once, and the core may run for a short time before the internal reset takes hold. During that time the block raises a RAM-access inhibit so that internal RAM cannot be written, while port accesses are still allowed. The CPU, the peripherals and the analog oscillator are outside this block; it only produces their enables, the reset and the mode.

Top module: `pwr_mode_ctl`

## Requirements
- R1: `int_rst` rises after the edge at which `rst_pin` has been sampled high on `RST_MC*MC_CLKS` (default 24) consecutive clock edges, and not before; it stays high while the pin stays high.
- R2: A low sample of `rst_pin` clears the width count, so `int_rst` is low after the next edge, and a later pulse again needs the full width.
- R3: `mode` is encoded as 2'b00 run, 2'b01 idle, 2'b10 power-down. In run, `cpu_clk_en`, `per_clk_en` and `osc_run` are all 1. In idle, `cpu_clk_en` is 0 and the other two are 1. In power-down, all three are 0, except that `osc_run` follows `rst_pin`.
- R4: In run, a `req_idle` sampled at an edge makes the mode idle after that edge. In idle, the mode returns to run after the first edge at which `irq_pend & irq_en` is non-zero.
- R5: A `req_pdown` in run enters power-down after the edge. Interrupts and requests leave power-down unchanged; only the internal reset ends it (mode run once `int_rst` rises).
- R6: When `req_idle` and `req_pdown` are sampled high together in run, the mode becomes power-down.
- R7: In idle, a pending interrupt whose enable bit is 0 does not wake the block, and `req_idle` or `req_pdown` leave the mode unchanged.
- R8: In idle, a high sample of `rst_pin` makes the mode run with `ram_inhibit` = 1 after that edge. `ram_inhibit` stays 1 and requests are ignored until the internal reset rises, which is at most `RST_MC*MC_CLKS` edges after the pin rose.
- R9: At the edge where `int_rst` rises, the mode becomes run and `ram_inhibit` becomes 0. While `int_rst` is high, requests are ignored.
- R10: If `rst_pin` falls while `ram_inhibit` is 1 and before the internal reset is reached, `ram_inhibit` is 0 after the next edge and the mode stays run.
- R11: After `rst_n` is sampled low, the mode is run, `ram_inhibit` is 0, `int_rst` is 0 and the width count is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rst_pin | input | 1 | External reset pin, active high |
| req_idle | input | 1 | Software request to enter idle |
| req_pdown | input | 1 | Software request to enter power-down |
| irq_pend | input | NUM_IRQ | Pending interrupt sources |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt clock enable |
| osc_run | output | 1 | Oscillator run enable |
| int_rst | output | 1 | Internal reset, active high |
| ram_inhibit | output | 1 | Blocks internal RAM access |
| mode | output | 2 | Current mode (00 run, 01 idle, 10 power-down) |

## Verification
The mode assertions assume that `clk` keeps toggling while `osc_run` is low, so that the reset pin can still be sampled in power-down. They also assume that the request and interrupt inputs are stable between clock edges. The bench meets both assumptions by running a free clock and changing every input only on the falling edge. It drives reset pulses of every length around the width threshold, drives all combinations of pending and enable bits from idle, and in every mode keeps the requests and the interrupts active at the same time as the pin.

// File: rtl/pwr_mode_pkg.sv
// Package: shared mode encoding for the power mode and reset controller.
// Assumes: a two-bit mode field that the neighbouring logic decodes.
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_PDOWN = 2'b10
    } pm_mode_e;
endpackage

// File: rtl/rst_width_filter.sv
// Module: rst_width_filter
// Counts consecutive high samples of the external reset pin on the
// oscillator clock. It raises the internal reset once the pin has been
// high for RST_MC machine cycles of MC_CLKS clocks each.
// Assumes: clk keeps running while the pin is high (the pin restarts the
// oscillator); rst_n is synchronous and active low.
module rst_width_filter #(
    parameter int MC_CLKS = 12,
    parameter int RST_MC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    output logic rst_int,
    output logic rst_hit
);
    localparam int THRESH = MC_CLKS * RST_MC;
    localparam int CNT_W  = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] LIMIT_M = CNT_W'(THRESH - 1);

    logic [CNT_W-1:0] cnt_q;

    // Width counter: clears on a low pin and saturates at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_pin) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Internal reset is asserted while the count sits at the threshold.
    assign rst_int = (cnt_q == LIMIT);

    // Reset takes hold at this edge (the count reaches or stays at the limit).
    assign rst_hit = rst_pin && (cnt_q >= LIMIT_M);

    // R2: a low pin sample drops the internal reset after the next edge.
    a_r2_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin |=> !rst_int);

    // R1: the internal reset is never high unless the pin was high before.
    a_r1_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_int) |-> $past(rst_pin));
endmodule

// File: rtl/pm_mode_fsm.sv
// Module: pm_mode_fsm
// Holds the run/idle/power-down state and the RAM-access inhibit. It
// applies the software requests (power-down wins), the wake-up on an enabled
// interrupt, and the hardware reset from idle, which resumes execution with
// RAM blocked until the internal reset takes hold.
// Assumes: rst_hit comes from the width filter and is high exactly at the
// edges where the internal reset is (or stays) asserted.
module pm_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int NUM_IRQ = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_pin,
    input  logic               rst_hit,
    input  logic               req_idle,
    input  logic               req_pdown,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    output pm_mode_e           mode_q,
    output logic               inh_q
);
    logic wake;

    // Wake condition: at least one source both pending and enabled.
    assign wake = |(irq_pend & irq_en);

    // Mode and inhibit update; the internal reset overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_hit) begin
            mode_q <= PM_RUN;
            inh_q  <= 1'b0;
        end else begin
            unique case (mode_q)
                PM_RUN: begin
                    if (inh_q) begin
                        if (!rst_pin) inh_q <= 1'b0;
                    end else if (req_pdown) begin
                        mode_q <= PM_PDOWN;
                    end else if (req_idle) begin
                        mode_q <= PM_IDLE;
                    end
                end
                PM_IDLE: begin
                    if (rst_pin) begin
                        mode_q <= PM_RUN;
                        inh_q  <= 1'b1;
                    end else if (wake) begin
                        mode_q <= PM_RUN;
                    end
                end
                PM_PDOWN: mode_q <= PM_PDOWN;
                default:  mode_q <= PM_RUN;
            endcase
        end
    end

    // R5: power-down is left only through the internal reset.
    a_r5_pdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_PDOWN && !rst_hit) |=> mode_q == PM_PDOWN);

    // R4: an enabled pending interrupt ends idle.
    a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_IDLE && wake && !rst_pin) |=> mode_q == PM_RUN);

    // R7: nothing but a wake or the pin leaves idle.
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_IDLE && !wake && !rst_pin) |=> mode_q == PM_IDLE);

    // R6: both requests together select power-down.
    a_r6_pdown_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_RUN && !inh_q && !rst_hit && req_idle && req_pdown)
        |=> mode_q == PM_PDOWN);

    // R8: the inhibit is only ever raised on leaving idle.
    a_r8_inh_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inh_q) |-> $past(mode_q) == PM_IDLE);

    // R9: the internal reset leaves run with no inhibit.
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit |=> (mode_q == PM_RUN && !inh_q));
endmodule

// File: rtl/pwr_mode_ctl.sv
// Module: pwr_mode_ctl (top)
// Power mode and reset controller: combines the reset width filter with
// the mode state machine and decodes the clock, oscillator and RAM enables.
// Assumes: clk is the oscillator clock and keeps running for pin sampling;
// osc_run restarts the oscillator whenever the reset pin is high.
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int MC_CLKS = 12,
    parameter int RST_MC  = 2,
    parameter int NUM_IRQ = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_pin,
    input  logic               req_idle,
    input  logic               req_pdown,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               osc_run,
    output logic               int_rst,
    output logic               ram_inhibit,
    output logic [1:0]         mode
);
    logic     rst_hit;
    pm_mode_e mode_q;
    logic     inh_q;

    // Reset pin qualification.
    rst_width_filter #(.MC_CLKS(MC_CLKS), .RST_MC(RST_MC)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_pin (rst_pin),
        .rst_int (int_rst),
        .rst_hit (rst_hit)
    );

    // Mode state and RAM inhibit.
    pm_mode_fsm #(.NUM_IRQ(NUM_IRQ)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_pin   (rst_pin),
        .rst_hit   (rst_hit),
        .req_idle  (req_idle),
        .req_pdown (req_pdown),
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .mode_q    (mode_q),
        .inh_q     (inh_q)
    );

    // Output decode of the clock and oscillator enables.
    always_comb begin
        cpu_clk_en  = (mode_q == PM_RUN);
        per_clk_en  = (mode_q != PM_PDOWN);
        osc_run     = (mode_q != PM_PDOWN) || rst_pin;
        ram_inhibit = inh_q;
        mode        = mode_q;
    end

    // R3: the CPU clock never runs while the peripheral clock is stopped.
    a_r3_clk_order: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (per_clk_en && osc_run));

    // R8: RAM is blocked only while the CPU is running.
    a_r8_inh_running: assert property (@(posedge clk) disable iff (!rst_n)
        ram_inhibit |-> cpu_clk_en);
endmodule

// File: tb/pwr_mode_ctl_bench.sv
module pwr_mode_ctl_bench;
    localparam int NI  = 5;
    localparam int THR = 24;

    logic          clk = 1'b0;
    logic          rst_n, rst_pin, req_idle, req_pdown;
    logic [NI-1:0] irq_pend, irq_en;
    logic          cpu_clk_en, per_clk_en, osc_run, int_rst, ram_inhibit;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pwr_mode_ctl #(.MC_CLKS(12), .RST_MC(2), .NUM_IRQ(NI)) u_pwr_mode_ctl (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .req_idle(req_idle),
        .req_pdown(req_pdown), .irq_pend(irq_pend), .irq_en(irq_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
        .int_rst(int_rst), .ram_inhibit(ram_inhibit), .mode(mode)
    );

    always #10ns clk = ~clk;

    // Compare one observed value with its expected value.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance n rising edges, then stop at the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Check the mode and the three enables implied by it (R3 encoding).
    task automatic chk_mode(input string req, input int m, input bit pin);
        chk({req, " mode"}, mode, m);
        chk({req, " cpu"}, cpu_clk_en, (m == 0) ? 1 : 0);
        chk({req, " per"}, per_clk_en, (m != 2) ? 1 : 0);
        chk({req, " osc"}, osc_run, ((m != 2) || pin) ? 1 : 0);
    endtask

    task automatic go_idle();
        req_idle = 1'b1; step(1); req_idle = 1'b0;
    endtask

    task automatic wake_up();
        irq_pend = '1; irq_en = '1; step(1); irq_pend = '0; irq_en = '0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rst_pin = 1'b0; req_idle = 1'b0; req_pdown = 1'b0;
        irq_pend = '0; irq_en = '0;
        step(2);
        // R11: state after the power-on reset.
        chk_mode("R11", 0, 1'b0);
        chk("R11 int_rst", int_rst, 0);
        chk("R11 inhibit", ram_inhibit, 0);
        rst_n = 1'b1;
        step(1);

        // R1/R2: every pulse length around the threshold, from run.
        for (int len = 1; len <= THR + 6; len++) begin
            rst_pin = 1'b1;
            for (int k = 1; k <= len; k++) begin
                step(1);
                chk("R1 width", int_rst, (k >= THR) ? 1 : 0);
            end
            rst_pin = 1'b0;
            step(1);
            chk("R2 clear", int_rst, 0);
            chk("R2 mode", mode, 0);
        end

        // R2: a short pulse then a gap restarts the count.
        rst_pin = 1'b1; step(THR - 2);
        rst_pin = 1'b0; step(1);
        rst_pin = 1'b1; step(THR - 1);
        chk("R2 restart", int_rst, 0);
        step(1);
        chk("R2 full", int_rst, 1);
        rst_pin = 1'b0; step(1);

        // R4/R7: all pending and enable combinations from idle.
        for (int p = 0; p < (1 << NI); p++) begin
            for (int e = 0; e < (1 << NI); e++) begin
                go_idle();
                chk_mode("R4 idle", 1, 1'b0);
                irq_pend = NI'(p); irq_en = NI'(e);
                step(1);
                chk((p & e) != 0 ? "R4 wake" : "R7 masked", mode,
                    ((p & e) != 0) ? 0 : 1);
                irq_pend = '0; irq_en = '0;
                if (mode == 2'b01) wake_up();
            end
        end

        // R7: requests ignored while idle.
        go_idle();
        req_pdown = 1'b1; req_idle = 1'b1; step(2);
        req_pdown = 1'b0; req_idle = 1'b0;
        chk_mode("R7 req ignored", 1, 1'b0);
        wake_up();
        chk_mode("R4 back to run", 0, 1'b0);

        // R6: both requests together.
        req_idle = 1'b1; req_pdown = 1'b1; step(1);
        req_idle = 1'b0; req_pdown = 1'b0;
        chk_mode("R6 priority", 2, 1'b0);

        // R5: power-down holds against interrupts, requests, short pulses.
        irq_pend = '1; irq_en = '1; req_idle = 1'b1; step(3);
        irq_pend = '0; irq_en = '0; req_idle = 1'b0;
        chk_mode("R5 sticky", 2, 1'b0);
        rst_pin = 1'b1; step(10);
        chk_mode("R5 pin osc", 2, 1'b1);
        chk("R5 no reset", int_rst, 0);
        rst_pin = 1'b0; step(1);
        chk_mode("R5 osc off", 2, 1'b0);
        rst_pin = 1'b1; step(THR - 1);
        chk_mode("R5 before", 2, 1'b1);
        step(1);
        chk("R5 reset", int_rst, 1);
        chk_mode("R5 exit", 0, 1'b1);
        // R9: requests ignored while the internal reset is held.
        req_idle = 1'b1; req_pdown = 1'b1; step(2);
        req_idle = 1'b0; req_pdown = 1'b0;
        chk_mode("R9 held", 0, 1'b1);
        rst_pin = 1'b0; step(1);

        // R8/R9: reset from idle, window length checked each edge.
        go_idle();
        rst_pin = 1'b1;
        for (int k = 1; k <= THR + 2; k++) begin
            if (k == 3) req_pdown = 1'b1;
            step(1);
            chk("R8 mode", mode, 0);
            chk("R8 cpu", cpu_clk_en, 1);
            chk((k < THR) ? "R8 inhibit" : "R9 inhibit", ram_inhibit,
                (k < THR) ? 1 : 0);
            chk("R9 int_rst", int_rst, (k >= THR) ? 1 : 0);
        end
        req_pdown = 1'b0;
        rst_pin = 1'b0; step(1);

        // R10: aborted pulse from idle.
        go_idle();
        rst_pin = 1'b1; step(5);
        chk("R10 inhibit on", ram_inhibit, 1);
        rst_pin = 1'b0; step(1);
        chk("R10 inhibit off", ram_inhibit, 0);
        chk("R10 mode", mode, 0);
        chk("R10 no reset", int_rst, 0);
        go_idle();
        chk_mode("R10 requests again", 1, 1'b0);
        wake_up();

        // R11: power-on reset from power-down.
        req_pdown = 1'b1; step(1); req_pdown = 1'b0;
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        chk_mode("R11 from pdown", 0, 1'b0);
        chk("R11 inhibit", ram_inhibit, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule